// File: doc/BRIEF.md
# NAND Page ECC Syndrome Classifier

This block compares the three-byte Hamming check code that was stored next to a 512-byte flash sector with the three-byte code recomputed from the sector data as it was read back. It sorts the difference into one of four outcomes:

- the two codes agree;
- a single data bit flipped, in which case the byte and bit where it sits are reported;
- a single bit of the stored check code itself flipped;
- the damage is beyond repair.

Both codes and a request strobe arrive in one cycle. One cycle later the block raises a single-cycle valid strobe together with the outcome. Flipping the faulty bit in the sector buffer is left to the surrounding logic, which uses the reported location.

Each code arrives as three bytes, with byte k on bits [8k+7:8k]. Before comparing, the block permutes each code into a 24-bit word in which the check bits form twelve adjacent pairs, from the lowest-order pair to the highest. The syndrome is the exclusive-or of the two words. A genuine single data-bit error leaves exactly one bit of every pair set, and the odd member of each pair then spells out one bit of the error location.

Top module: `ecc_syndrome_classifier`

## Requirements
- R1: When `read_code_i` equals `calc_code_i`, the result has status 2'b00 (clean).
- R2: Each code is permuted into the word {byte2[1:0], byte1, byte0, byte2[7:2]}, so byte2[7:2] lands in word bits 5..0. The syndrome s is the bitwise XOR of the two permuted words.
- R3: When every pair (s[2j+1], s[2j]) for j = 0..11 has at least one bit set, the status is 2'b01 (data bit corrected). This holds even when both bits of some pairs are set.
- R4: With status 2'b01, `bit_idx_o` equals {s[5], s[3], s[1]}.
- R5: With status 2'b01, `byte_addr_o` equals {s[23], s[21], s[19], s[17], s[15], s[13], s[11], s[9], s[7]}.
- R6: When exactly one bit of s is set, the status is 2'b10 (error in the stored code only).
- R7: Any other nonzero syndrome, including one with some pair entirely clear, gives status 2'b11 (uncorrectable).
- R8: `byte_addr_o` and `bit_idx_o` are zero whenever the status is not 2'b01.
- R9: A request sampled on a clock edge produces a result and a `valid_o` pulse after that same edge. The pulse lasts one cycle per request, so back-to-back requests give back-to-back pulses in order. Without a request, `valid_o` stays low and the result outputs hold their last value.
- R10: While `rst_n` is low at a clock edge, `valid_o`, the status and both location outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Classification request strobe |
| read_code_i | input | 24 | Check code read from flash; byte k on [8k+7:8k] |
| calc_code_i | input | 24 | Check code recomputed from data; byte k on [8k+7:8k] |
| valid_o | output | 1 | Result valid, one cycle per request |
| status_o | output | 2 | 00 clean, 01 data fix, 10 code-only error, 11 uncorrectable |
| byte_addr_o | output | 9 | Byte offset of the faulty data bit within the sector |
| bit_idx_o | output | 3 | Bit position of the faulty data bit within that byte |

## Verification
The output register can present the result of one request in the same cycle that it captures the next. Back-to-back strobes are therefore driven with codes from different outcome classes, for example a clean pair followed by a correctable one and then an uncorrectable one. A scoreboard queue, filled when each request is issued, judges that every pulse carries the outcome of its own request, in order, with no pulse lost or doubled. Idle gaps after such bursts confirm that the last result holds and that no stray pulse appears.

// File: rtl/eccfix_pkg.sv
// Package: shared widths and result types for the ECC syndrome classifier.
// Assumes a three-byte Hamming code protecting a 512-byte sector, so the
// syndrome holds twelve bit pairs: three select the bit, nine the byte.
package eccfix_pkg;

    localparam int BYTE_W     = 8;
    localparam int CODE_BYTES = 3;
    localparam int CODE_W     = BYTE_W * CODE_BYTES;
    localparam int WRAP_W     = 2;
    localparam int PAIRS      = CODE_W / 2;
    localparam int BIT_IDX_W  = 3;
    localparam int ADDR_W     = PAIRS - BIT_IDX_W;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'b00,
        ST_DATA_FIX = 2'b01,
        ST_ECC_ONLY = 2'b10,
        ST_FATAL    = 2'b11
    } ecc_status_e;

    typedef struct packed {
        ecc_status_e            status;
        logic [ADDR_W-1:0]      byte_addr;
        logic [BIT_IDX_W-1:0]   bit_idx;
    } ecc_result_t;

endpackage

// File: rtl/ecc_word_pack.sv
// Module: ecc_word_pack
// Permutes a three-byte check code into the pair-ordered word. The low
// WRAP_W bits of the top byte become the top of the word, the middle and
// low bytes follow, and the rest of the top byte fills the bottom.
// Assumes CODE_BYTES == 3 and WRAP_W < BYTE_W. Purely combinational.
module ecc_word_pack #(
    parameter int BYTE_W = 8,
    parameter int WRAP_W = 2,
    localparam int CODE_W = 3 * BYTE_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] word_o
);

    logic [BYTE_W-1:0] byte0;
    logic [BYTE_W-1:0] byte1;
    logic [BYTE_W-1:0] byte2;

    // Split the code into its three bytes.
    assign byte0 = code_i[BYTE_W-1:0];
    assign byte1 = code_i[2*BYTE_W-1:BYTE_W];
    assign byte2 = code_i[3*BYTE_W-1:2*BYTE_W];

    // Reassemble in ascending pair order.
    assign word_o = {byte2[WRAP_W-1:0], byte1, byte0, byte2[BYTE_W-1:WRAP_W]};

endmodule

// File: rtl/ecc_pair_reduce.sv
// Module: ecc_pair_reduce
// Walks the syndrome pair by pair. It reports whether every pair has at
// least one bit set, and it extracts the odd (upper) bit of each pair,
// which carries the location. Combinational.
module ecc_pair_reduce #(
    parameter int PAIRS = 12,
    localparam int WORD_W = 2 * PAIRS
) (
    input  logic [WORD_W-1:0] syn_i,
    output logic [PAIRS-1:0]  odd_o,
    output logic              all_pairs_o
);

    logic [PAIRS-1:0] pair_hit;

    // One slice per pair: occupancy flag and location bit.
    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        assign pair_hit[j] = syn_i[2*j] | syn_i[2*j+1];
        assign odd_o[j]    = syn_i[2*j+1];
    end

    // Correctable shape only when no pair is empty.
    assign all_pairs_o = &pair_hit;

endmodule

// File: rtl/ecc_weight_check.sv
// Module: ecc_weight_check
// Flags a zero syndrome and a syndrome with exactly one bit set. Clearing
// the lowest set bit (s & (s-1)) avoids a full population count.
// Combinational.
module ecc_weight_check #(
    parameter int WORD_W = 24
) (
    input  logic [WORD_W-1:0] syn_i,
    output logic              is_zero_o,
    output logic              is_single_o
);

    localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

    logic [WORD_W-1:0] low_cleared;

    // Drop the lowest set bit.
    assign low_cleared = syn_i & (syn_i - ONE);

    // Zero and single-bit tests.
    assign is_zero_o   = (syn_i == '0);
    assign is_single_o = !is_zero_o && (low_cleared == '0);

endmodule

// File: rtl/ecc_classify.sv
// Module: ecc_classify
// Turns the syndrome flags into a status and location, in this order:
// clean, correctable, code-only, uncorrectable. The location is filled
// only for the correctable outcome. Assumes PAIRS = ADDR_W + BIT_IDX_W.
module ecc_classify
    import eccfix_pkg::*;
(
    input  logic [PAIRS-1:0] odd_i,
    input  logic             all_pairs_i,
    input  logic             is_zero_i,
    input  logic             is_single_i,
    output ecc_result_t      result_o
);

    // Priority decode of the outcome.
    always_comb begin
        result_o = '0;
        if (is_zero_i) begin
            result_o.status = ST_CLEAN;
        end else if (all_pairs_i) begin
            result_o.status    = ST_DATA_FIX;
            result_o.bit_idx   = odd_i[BIT_IDX_W-1:0];
            result_o.byte_addr = odd_i[PAIRS-1:BIT_IDX_W];
        end else if (is_single_i) begin
            result_o.status = ST_ECC_ONLY;
        end else begin
            result_o.status = ST_FATAL;
        end
    end

endmodule

// File: rtl/ecc_syndrome_classifier.sv
// Module: ecc_syndrome_classifier (top)
// Compares a stored check code with a recomputed one and registers the
// classification. The result appears one cycle after the request,
// qualified by a one-cycle valid pulse, and holds until the next request.
// Assumes synchronous active-low reset and the code layout in eccfix_pkg.
module ecc_syndrome_classifier
    import eccfix_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [CODE_W-1:0]    read_code_i,
    input  logic [CODE_W-1:0]    calc_code_i,
    output logic                 valid_o,
    output logic [1:0]           status_o,
    output logic [ADDR_W-1:0]    byte_addr_o,
    output logic [BIT_IDX_W-1:0] bit_idx_o
);

    logic [CODE_W-1:0] read_word;
    logic [CODE_W-1:0] calc_word;
    logic [CODE_W-1:0] syndrome;
    logic [PAIRS-1:0]  odd_bits;
    logic              all_pairs;
    logic              is_zero;
    logic              is_single;
    ecc_result_t       next_result;
    ecc_result_t       result_q;
    logic              valid_q;

    ecc_word_pack #(.BYTE_W(BYTE_W), .WRAP_W(WRAP_W)) u_pack_read (
        .code_i (read_code_i),
        .word_o (read_word)
    );

    ecc_word_pack #(.BYTE_W(BYTE_W), .WRAP_W(WRAP_W)) u_pack_calc (
        .code_i (calc_code_i),
        .word_o (calc_word)
    );

    // Syndrome of the two pair-ordered words.
    assign syndrome = read_word ^ calc_word;

    ecc_pair_reduce #(.PAIRS(PAIRS)) u_pairs (
        .syn_i       (syndrome),
        .odd_o       (odd_bits),
        .all_pairs_o (all_pairs)
    );

    ecc_weight_check #(.WORD_W(CODE_W)) u_weight (
        .syn_i       (syndrome),
        .is_zero_o   (is_zero),
        .is_single_o (is_single)
    );

    ecc_classify u_classify (
        .odd_i       (odd_bits),
        .all_pairs_i (all_pairs),
        .is_zero_i   (is_zero),
        .is_single_i (is_single),
        .result_o    (next_result)
    );

    // Capture the result on request and pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            valid_q <= req_i;
            if (req_i) begin
                result_q <= next_result;
            end
        end
    end

    assign valid_o     = valid_q;
    assign status_o    = result_q.status;
    assign byte_addr_o = result_q.byte_addr;
    assign bit_idx_o   = result_q.bit_idx;

endmodule

// File: rtl/ecc_syndrome_classifier_chk.sv
// Module: ecc_syndrome_classifier_chk
// Port-level properties of the classifier, bound to the top module.
module ecc_syndrome_classifier_chk
    import eccfix_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_i,
    input logic [CODE_W-1:0]    read_code_i,
    input logic [CODE_W-1:0]    calc_code_i,
    input logic                 valid_o,
    input logic [1:0]           status_o,
    input logic [ADDR_W-1:0]    byte_addr_o,
    input logic [BIT_IDX_W-1:0] bit_idx_o
);

    // Equal codes are reported clean (R1).
    p_equal_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && read_code_i == calc_code_i) |=> status_o == 2'b00);

    // One differing raw bit is a code-only error, since the permutation keeps weight (R6).
    p_single_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && $countones(read_code_i ^ calc_code_i) == 1) |=> status_o == 2'b10);

    // Location is zero outside the correctable outcome (R8).
    p_loc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'b01) |-> (byte_addr_o == '0 && bit_idx_o == '0));

    // A request gives a pulse on the next cycle (R9).
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    // Without a request there is no pulse and the result holds (R9).
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && $stable(status_o) && $stable(byte_addr_o) && $stable(bit_idx_o)));

endmodule

bind ecc_syndrome_classifier ecc_syndrome_classifier_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .read_code_i (read_code_i),
    .calc_code_i (calc_code_i),
    .valid_o     (valid_o),
    .status_o    (status_o),
    .byte_addr_o (byte_addr_o),
    .bit_idx_o   (bit_idx_o)
);

// File: tb/ecc_syndrome_classifier_bench.sv
module ecc_syndrome_classifier_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [23:0] read_code_i = '0;
    logic [23:0] calc_code_i = '0;
    logic        valid_o;
    logic [1:0]  status_o;
    logic [8:0]  byte_addr_o;
    logic [2:0]  bit_idx_o;

    int checks = 0;
    int errors = 0;
    logic [13:0] exp_q [$];
    string       tag_q [$];
    logic [13:0] last_exp = '0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    ecc_syndrome_classifier u_ecc_syndrome_classifier (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .read_code_i (read_code_i),
        .calc_code_i (calc_code_i),
        .valid_o     (valid_o),
        .status_o    (status_o),
        .byte_addr_o (byte_addr_o),
        .bit_idx_o   (bit_idx_o)
    );

    // Expected {status, byte, bit} from a syndrome, per R1, R3..R8.
    function automatic logic [13:0] model(input logic [23:0] s);
        logic [1:0] st;
        logic [8:0] ad;
        logic [2:0] bi;
        st = 2'b11; ad = '0; bi = '0;
        if (s == 24'h0) st = 2'b00;
        else if (((s | (s >> 1)) & 24'h555555) == 24'h555555) begin
            st = 2'b01;
            bi = {s[5], s[3], s[1]};
            for (int k = 0; k < 9; k++) ad[k] = s[2*k+7];
        end else if ($countones(s) == 1) st = 2'b10;
        return {st, ad, bi};
    endfunction

    // Syndrome of a genuine single-bit error at {byte, bit} (R3, R4, R5).
    function automatic logic [23:0] build(input logic [8:0] ad, input logic [2:0] bi);
        logic [11:0] loc;
        logic [23:0] s;
        loc = {ad, bi};
        for (int j = 0; j < 12; j++) begin
            s[2*j+1] = loc[j];
            s[2*j]   = ~loc[j];
        end
        return s;
    endfunction

    // Raw byte-level difference yielding syndrome s under the R2 permutation.
    function automatic logic [23:0] unpack(input logic [23:0] s);
        return {s[5:0], s[23:22], s[21:14], s[13:6]};
    endfunction

    // Driver: issue one request and push its expectation.
    task automatic send(input logic [23:0] s, input string tag);
        logic [23:0] base;
        base = $urandom();
        calc_code_i = base;
        read_code_i = base ^ unpack(s);
        req_i = 1'b1;
        exp_q.push_back(model(s));
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pop and compare on each pulse; check that the result holds when idle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (valid_o) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9: pulse with no request, got st=%b expected none", status_o);
                end else begin
                    logic [13:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    last_exp = e;
                    if ({status_o, byte_addr_o, bit_idx_o} !== e) begin
                        errors++;
                        $display("FAIL %s: got st=%b byte=%h bit=%0d expected st=%b byte=%h bit=%0d",
                                 t, status_o, byte_addr_o, bit_idx_o, e[13:12], e[11:3], e[2:0]);
                    end
                end
            end else if (!req_i && exp_q.size() == 0) begin
                checks++;
                if ({status_o, byte_addr_o, bit_idx_o} !== last_exp) begin
                    errors++;
                    $display("FAIL R9: hold got %h expected %h", {status_o, byte_addr_o, bit_idx_o}, last_exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state.
        checks++;
        if ({valid_o, status_o, byte_addr_o, bit_idx_o} !== 15'h0) begin
            errors++;
            $display("FAIL R10: got %h expected 0", {valid_o, status_o, byte_addr_o, bit_idx_o});
        end
        rst_n = 1'b1;
        @(negedge clk);

        send(24'h000000, "R1");          idle(2);
        send(24'h555555, "R3_R4_R5");    idle(2);
        send(24'hAAAAAA, "R3_R4_R5");    idle(2);
        send(build(9'h0A5, 3'd3), "R2_R5"); idle(1);
        send(build(9'h100, 3'd4), "R2_R4"); idle(1);
        send(build(9'h001, 3'd1), "R2_R4_R5"); idle(1);
        send(24'hFFFFFF, "R3");          idle(1);
        send(24'h000001, "R6_R8");       idle(1);
        send(24'h800000, "R6_R8");       idle(1);
        send(24'h000800, "R6");          idle(1);
        send(24'h000003, "R7_R8");       idle(1);
        send(24'h555554, "R7");          idle(1);
        send(24'h155555, "R7");          idle(1);
        // Back-to-back requests of differing classes (R9).
        send(24'h000000, "R9");
        send(build(9'h1C3, 3'd6), "R9");
        send(24'h000006, "R9");
        send(24'h000010, "R9");
        send(build(9'h07E, 3'd0), "R9");
        idle(4);
        for (int i = 0; i < 40; i++) begin
            logic [23:0] s;
            s = $urandom();
            send(s, "R7");
            if (i % 3 == 0) idle(1);
        end
        for (int i = 0; i < 40; i++) begin
            logic [11:0] loc;
            loc = $urandom();
            send(build(loc[11:3], loc[2:0]), "R4_R5");
        end
        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: missing pulses got %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule